// File: doc/BRIEF.md
# Programmable Peripheral Address Window Decoder

This block sits between a system bus and a set of external peripheral channels. Software programs each channel with a start address and a power-of-two size exponent. For every bus request the block checks the address against all channel windows and against two fixed internal register regions. It then answers in one of three ways: it pulses the chip select of the winning channel, it pulses a bus-error response, or it marks the access as local. A bus error or a local access never drives any external chip select.

A window begins at the programmed start address, which need not be aligned. It ends at the last byte before the next multiple of its size. Each channel forces some of its upper start-address bits, so software cannot move it out of its region. One channel has a fixed 4-byte window. Two channels share one chip-select line, and the peripheral tells them apart by address bit 26. When windows overlap, the lowest-numbered channel wins and a sticky overlap indicator is set. Each channel also keeps a sticky address-error flag, which software clears by writing 1 to it.

A finite-state machine sequences each request through these states:
- `ST_IDLE` to `ST_LOOKUP` when `req_valid` is high. The address is captured here.
- `ST_LOOKUP` to `ST_LOCAL` if the address lies in an internal region.
- `ST_LOOKUP` to `ST_SELECT` if any channel matches.
- `ST_LOOKUP` to `ST_FAULT` otherwise.
- `ST_SELECT`, `ST_FAULT` and `ST_LOCAL` each last one cycle and return to `ST_IDLE`.

A request offered outside `ST_IDLE` is not taken.

Top module: `adw_decoder`

## Requirements
- R1: `reg_kind`=0 selects the start-address register of channel `reg_ch`. It stores bits 28:0 and reads bits 31:29 as zero. Forced bits are applied on every write:
  - channel 0 forces bits 28:24 to 0x1F;
  - channel 1 forces bits 28:25 to 0xF (region 0x1E000000);
  - channel 2 forces all bits to 0x10000000;
  - channel 3 forces bits 28:26 to 0b101 (region 0x14000000).
- R2: `reg_kind`=1 selects the config word. The size exponent n is at bits 20:16, and a written value above 27 is stored as 27. The address-error flag reads at bit 28. All other bits read as zero.
- R3: A channel matches address A when A>>n equals start>>n and A >= start. An unaligned start therefore gives a window from the start up to the next size-aligned boundary.
- R4: A start of 0x1FFFFFFF matches only the single byte 0x1FFFFFFF, whatever the size.
- R5: Channel 1 always uses a 4-byte window (n=2) and ignores its programmed size, both for chip select and for bus error.
- R6: On a match, exactly one line of `cs_n` goes low, for exactly the one cycle that begins two clock edges after the request edge. The line mapping is channel 0 to line 0, channel 1 to line 1, and channels 2 and 3 to line 2.
- R7: With no match and no local hit, `bus_err` pulses high for that same one cycle and every `cs_n` stays high.
- R8: Addresses 0x1D000000–0x1DFFFFFF and 0x1F800000–0x1F8FFFFF raise `local_sel` for that cycle. They assert no chip select, no bus error and no address-error flag, even when a channel window covers them.
- R9: When several channels match, the lowest-numbered one drives its line, and `ov_seen` goes high and stays high until reset.
- R10: A channel's address-error flag is set when an access (not local) lies in the channel's size-aligned block but below its start. Writing a config word with bit 28 = 1 clears the flag; writing 0 there leaves it unchanged.
- R11: After reset the registers hold the following, with all flags clear, all `cs_n` high, and `bus_err`, `local_sel` and `ov_seen` low:

| Channel | Start | n |
|---|---|---|
| 0 | 0x1F000000 | 16 |
| 1 | 0x1E000000 | 2 |
| 2 | 0x10000000 | 20 |
| 3 | 0x14000000 | 20 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_kind | input | 1 | 0 = start register, 1 = config word |
| reg_ch | input | 2 | Channel index for register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Bus request strobe |
| req_addr | input | 29 | Physical request address |
| cs_n | output | 3 | Active-low chip selects |
| bus_err | output | 1 | Bus-error response pulse |
| local_sel | output | 1 | Internal-region access pulse |
| ov_seen | output | 1 | Sticky window-overlap indicator |

## Verification
The bench goes after the edges of unaligned windows: the last byte before the aligned boundary, the first byte after it, and the byte just below the start. A decoder that aligned the start downward would select on that lower byte and never raise the flag. It probes the 0x1FFFFFFF start and the fixed 4-byte channel, where honouring the programmed size would wrongly select past the fourth byte. It places a channel over an internal region, where a missing exclusion would pulse a chip select or set a flag. It also builds an overlapping pair of windows, where a reversed priority would drive the wrong line.

// File: rtl/adw_pkg.sv
package adw_pkg;
    localparam int SZW      = 5;
    localparam int MAXN     = 27;
    localparam int CFG_NLSB = 16;
    localparam int CFG_FLAG = 28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SELECT,
        ST_FAULT,
        ST_LOCAL
    } adw_state_e;
endpackage

// File: rtl/adw_chan.sv
module adw_chan
    import adw_pkg::*;
#(
    parameter int             PAW       = 29,
    parameter logic [PAW-1:0] FMASK     = '0,
    parameter logic [PAW-1:0] FVAL      = '0,
    parameter logic [PAW-1:0] RST_START = '0,
    parameter logic [SZW-1:0] RST_N     = '0,
    parameter bit             FIXED     = 1'b0,
    parameter logic [SZW-1:0] FIX_N     = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_start,
    input  logic           wr_cfg,
    input  logic [PAW-1:0] wr_addr,
    input  logic [SZW-1:0] wr_n,
    input  logic           wr_clr,
    input  logic [PAW-1:0] addr,
    input  logic           flag_set_en,
    output logic [31:0]    rd_start,
    output logic [31:0]    rd_cfg,
    output logic           hit,
    output logic           below
);
    localparam logic [SZW-1:0] NMAX = SZW'(MAXN);

    logic [PAW-1:0] start_q;
    logic [SZW-1:0] n_q;
    logic           flag_q;
    logic [SZW-1:0] n_eff;
    logic [PAW-1:0] hi_mask;
    logic           same_blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= (RST_START & ~FMASK) | (FVAL & FMASK);
            n_q     <= RST_N;
            flag_q  <= 1'b0;
        end else begin
            if (wr_start)
                start_q <= (wr_addr & ~FMASK) | (FVAL & FMASK);
            if (wr_cfg)
                n_q <= (wr_n > NMAX) ? NMAX : wr_n;
            if (flag_set_en && below)
                flag_q <= 1'b1;
            else if (wr_cfg && wr_clr)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        n_eff    = FIXED ? FIX_N : n_q;
        hi_mask  = {PAW{1'b1}} << n_eff;
        same_blk = ((addr ^ start_q) & hi_mask) == '0;
        hit      = same_blk && (addr >= start_q);
        below    = same_blk && (addr < start_q);
        rd_start = {{(32-PAW){1'b0}}, start_q};
        rd_cfg   = '0;
        rd_cfg[CFG_NLSB +: SZW] = n_q;
        rd_cfg[CFG_FLAG]        = flag_q;
    end
endmodule

// File: rtl/adw_pick.sv
module adw_pick #(
    parameter int NCH  = 4,
    parameter int NCS  = 3,
    parameter int CSW  = 2,
    parameter int PAW  = 29,
    parameter int NLOC = 2,
    parameter int SZW  = 5,
    parameter logic [NCH-1:0][CSW-1:0]  CS_MAP   = '0,
    parameter logic [NLOC-1:0][PAW-1:0] LOC_BASE = '0,
    parameter logic [NLOC-1:0][SZW-1:0] LOC_N    = '0
) (
    input  logic [NCH-1:0] hit,
    input  logic [PAW-1:0] addr,
    output logic           any_hit,
    output logic           multi,
    output logic           is_local,
    output logic [NCS-1:0] cs_vec
);
    logic [NLOC-1:0] loc_hit;

    for (genvar j = 0; j < NLOC; j++) begin : g_loc
        assign loc_hit[j] =
            ((addr ^ LOC_BASE[j]) & ({PAW{1'b1}} << LOC_N[j])) == '0;
    end

    always_comb begin
        int cnt;
        cnt    = 0;
        cs_vec = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                cs_vec = '0;
                cs_vec[CS_MAP[i]] = 1'b1;
                cnt = cnt + 1;
            end
        end
        any_hit  = |hit;
        multi    = cnt > 1;
        is_local = |loc_hit;
    end
endmodule

// File: rtl/adw_decoder.sv
module adw_decoder
    import adw_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NCS  = 3,
    parameter int PAW  = 29,
    parameter int NLOC = 2,
    parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int CSW  = (NCS > 1) ? $clog2(NCS) : 1,
    parameter logic [NCH-1:0][PAW-1:0] CH_FMASK =
        {29'h1C000000, 29'h1FFFFFFF, 29'h1E000000, 29'h1F000000},
    parameter logic [NCH-1:0][PAW-1:0] CH_FVAL =
        {29'h14000000, 29'h10000000, 29'h1E000000, 29'h1F000000},
    parameter logic [NCH-1:0][PAW-1:0] CH_RST_START =
        {29'h14000000, 29'h10000000, 29'h1E000000, 29'h1F000000},
    parameter logic [NCH-1:0][SZW-1:0] CH_RST_N = {5'd20, 5'd20, 5'd2, 5'd16},
    parameter logic [NCH-1:0]          CH_FIXED = 4'b0010,
    parameter logic [NCH-1:0][SZW-1:0] CH_FIX_N = {5'd0, 5'd0, 5'd2, 5'd0},
    parameter logic [NCH-1:0][CSW-1:0] CH_CS    = {2'd2, 2'd2, 2'd1, 2'd0},
    parameter logic [NLOC-1:0][PAW-1:0] LOC_BASE = {29'h1F800000, 29'h1D000000},
    parameter logic [NLOC-1:0][SZW-1:0] LOC_N    = {5'd20, 5'd24}
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic           reg_kind,
    input  logic [CHW-1:0] reg_ch,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           req_valid,
    input  logic [PAW-1:0] req_addr,
    output logic [NCS-1:0] cs_n,
    output logic           bus_err,
    output logic           local_sel,
    output logic           ov_seen
);
    adw_state_e state_q, state_d;
    logic [PAW-1:0] addr_q;
    logic [NCS-1:0] cs_sel_q;
    logic           ov_q;

    logic [NCH-1:0]       hit, below, wr_start, wr_cfg;
    logic [NCH-1:0][31:0] rd_start, rd_cfg;
    logic                 any_hit, multi, is_local, flag_set_en;
    logic [NCS-1:0]       cs_vec;
    logic                 unused_hi;

    assign unused_hi   = ^reg_wdata[31:29];
    assign flag_set_en = (state_q == ST_LOOKUP) && !is_local;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_start[i] = reg_we && !reg_kind && (reg_ch == CHW'(i));
        assign wr_cfg[i]   = reg_we &&  reg_kind && (reg_ch == CHW'(i));

        adw_chan #(
            .PAW(PAW), .FMASK(CH_FMASK[i]), .FVAL(CH_FVAL[i]),
            .RST_START(CH_RST_START[i]), .RST_N(CH_RST_N[i]),
            .FIXED(CH_FIXED[i]), .FIX_N(CH_FIX_N[i])
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_start(wr_start[i]), .wr_cfg(wr_cfg[i]),
            .wr_addr(reg_wdata[PAW-1:0]),
            .wr_n(reg_wdata[CFG_NLSB +: SZW]),
            .wr_clr(reg_wdata[CFG_FLAG]),
            .addr(addr_q), .flag_set_en(flag_set_en),
            .rd_start(rd_start[i]), .rd_cfg(rd_cfg[i]),
            .hit(hit[i]), .below(below[i])
        );
    end

    adw_pick #(
        .NCH(NCH), .NCS(NCS), .CSW(CSW), .PAW(PAW), .NLOC(NLOC), .SZW(SZW),
        .CS_MAP(CH_CS), .LOC_BASE(LOC_BASE), .LOC_N(LOC_N)
    ) u_pick (
        .hit(hit), .addr(addr_q), .any_hit(any_hit), .multi(multi),
        .is_local(is_local), .cs_vec(cs_vec)
    );

    assign reg_rdata = reg_kind ? rd_cfg[reg_ch] : rd_start[reg_ch];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (is_local)     state_d = ST_LOCAL;
                else if (any_hit) state_d = ST_SELECT;
                else              state_d = ST_FAULT;
            end
            ST_SELECT: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            ST_LOCAL:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // captured request and decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            cs_sel_q <= '0;
            ov_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid)
                addr_q <= req_addr;
            if (state_q == ST_LOOKUP) begin
                cs_sel_q <= cs_vec;
                if (multi && !is_local)
                    ov_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cs_n      = (state_q == ST_SELECT) ? ~cs_sel_q : '1;
        bus_err   = (state_q == ST_FAULT);
        local_sel = (state_q == ST_LOCAL);
        ov_seen   = ov_q;
    end
endmodule

// File: rtl/adw_decoder_chk.sv
module adw_decoder_chk #(
    parameter int NCS = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [NCS-1:0] cs_n,
    input logic           bus_err,
    input logic           local_sel,
    input logic           ov_seen
);
    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R6
    AST_CS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |=> (&cs_n)); // R6
    AST_RESP_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err || local_sel || !(&cs_n)) |-> $past(req_valid, 2)); // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (&cs_n)); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err); // R7
    AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        local_sel |-> ((&cs_n) && !bus_err)); // R8
    AST_OVL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ov_seen |=> ov_seen); // R9
endmodule

bind adw_decoder adw_decoder_chk #(.NCS(NCS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cs_n(cs_n),
    .bus_err(bus_err), .local_sel(local_sel), .ov_seen(ov_seen)
);

// File: tb/tb_adw_decoder.sv
module tb_adw_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_kind = 1'b0;
    logic [1:0]  reg_ch = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [28:0] req_addr = '0;
    logic [2:0]  cs_n;
    logic        bus_err, local_sel, ov_seen;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adw_decoder dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_kind(reg_kind),
        .reg_ch(reg_ch), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .cs_n(cs_n),
        .bus_err(bus_err), .local_sel(local_sel), .ov_seen(ov_seen)
    );

    // {addr, cs_n, bus_err, local_sel} against reset configuration
    localparam logic [33:0] VEC [11] = '{
        {29'h1F000010, 3'b110, 1'b0, 1'b0},
        {29'h1F00FFFF, 3'b110, 1'b0, 1'b0},
        {29'h1F010000, 3'b111, 1'b1, 1'b0},
        {29'h1E000003, 3'b101, 1'b0, 1'b0},
        {29'h1E000004, 3'b111, 1'b1, 1'b0},
        {29'h10000000, 3'b011, 1'b0, 1'b0},
        {29'h140FFFFF, 3'b011, 1'b0, 1'b0},
        {29'h14100000, 3'b111, 1'b1, 1'b0},
        {29'h1D123456, 3'b111, 1'b0, 1'b1},
        {29'h1F800010, 3'b111, 1'b0, 1'b1},
        {29'h00000000, 3'b111, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic kind, input logic [1:0] ch, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_kind = kind; reg_ch = ch; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input string req, input logic kind, input logic [1:0] ch,
                          input logic [31:0] exp);
        @(negedge clk);
        reg_kind = kind; reg_ch = ch;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // exp = {cs_n, bus_err, local_sel}
    task automatic access(input string req, input logic [28:0] a, input logic [4:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(req, {27'd0, cs_n, bus_err, local_sel}, {27'd0, exp});
        @(negedge clk);
        check(req, {27'd0, cs_n, bus_err, local_sel}, {27'd0, 5'b11100});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        check("R11", {27'd0, cs_n, bus_err, local_sel}, {27'd0, 5'b11100});
        check("R11", {31'd0, ov_seen}, 32'd0);
        rd_reg("R11", 1'b0, 2'd0, 32'h1F000000);
        rd_reg("R11", 1'b1, 2'd0, 32'h00100000);
        rd_reg("R11", 1'b0, 2'd1, 32'h1E000000);
        rd_reg("R11", 1'b1, 2'd1, 32'h00020000);
        rd_reg("R11", 1'b0, 2'd2, 32'h10000000);
        rd_reg("R11", 1'b1, 2'd3, 32'h00140000);

        // table walk (R6, R7, R8, R5 via the 0x1E000004 entry)
        for (int i = 0; i < 11; i++) begin
            string tag;
            tag = VEC[i][0] ? "R8" : (VEC[i][1] ? "R7" : "R6");
            access(tag, VEC[i][33:5], VEC[i][4:0]);
        end

        // R1 forced bits and readback
        wr_reg(1'b0, 2'd0, 32'hFFFF1234);
        rd_reg("R1", 1'b0, 2'd0, 32'h1FFF1234);
        wr_reg(1'b0, 2'd3, 32'h00000100);
        rd_reg("R1", 1'b0, 2'd3, 32'h14000100);
        wr_reg(1'b0, 2'd2, 32'h12345678);
        rd_reg("R1", 1'b0, 2'd2, 32'h10000000);
        wr_reg(1'b0, 2'd1, 32'h00000010);
        rd_reg("R1", 1'b0, 2'd1, 32'h1E000010);

        // R2 size saturation and zero fields
        wr_reg(1'b1, 2'd0, 32'hFFFFFFFF);
        rd_reg("R2", 1'b1, 2'd0, 32'h001B0000);

        // R3 unaligned window, R10 flag
        wr_reg(1'b1, 2'd3, 32'h000C0000);
        access("R3", 29'h14000FFF, 5'b01100);
        access("R3", 29'h14001000, 5'b11110);
        access("R3", 29'h140000FF, 5'b11110);
        rd_reg("R10", 1'b1, 2'd3, 32'h100C0000);
        wr_reg(1'b1, 2'd3, 32'h000C0000);
        rd_reg("R10", 1'b1, 2'd3, 32'h100C0000);
        wr_reg(1'b1, 2'd3, 32'h100C0000);
        rd_reg("R10", 1'b1, 2'd3, 32'h000C0000);

        // R5 fixed four-byte window
        wr_reg(1'b1, 2'd1, 32'h00140000);
        rd_reg("R5", 1'b1, 2'd1, 32'h00140000);
        access("R5", 29'h1E000013, 5'b10100);
        access("R5", 29'h1E000014, 5'b11110);

        // R4 top-of-region one-byte window
        wr_reg(1'b1, 2'd0, 32'h10080000);
        wr_reg(1'b0, 2'd0, 32'h1FFFFFFF);
        access("R4", 29'h1FFFFFFF, 5'b11000);
        access("R4", 29'h1FFFFFFE, 5'b11110);
        check("R9", {31'd0, ov_seen}, 32'd0);

        // R8 internal region beats a covering window, no flag
        wr_reg(1'b1, 2'd0, 32'h10100000);
        wr_reg(1'b0, 2'd0, 32'h1F800010);
        access("R8", 29'h1F800004, 5'b11101);
        rd_reg("R8", 1'b1, 2'd0, 32'h00100000);
        check("R8", {31'd0, ov_seen}, 32'd0);

        // R9 overlap priority and sticky indicator
        wr_reg(1'b0, 2'd0, 32'h1F000000);
        wr_reg(1'b1, 2'd0, 32'h00080000);
        wr_reg(1'b0, 2'd1, 32'h1F000000);
        access("R9", 29'h1F000002, 5'b11000);
        check("R9", {31'd0, ov_seen}, 32'd1);
        access("R9", 29'h1F000005, 5'b11000);
        check("R9", {31'd0, ov_seen}, 32'd1);
        wr_reg(1'b1, 2'd2, 32'h001B0000);
        access("R6", 29'h14000800, 5'b01100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule